// File: doc/BRIEF.md
# Event timer comparator channel

This block is one comparator channel of a multi-channel event timer. A shared main counter of up to 64 bits runs outside the block and is fed in every cycle. The channel keeps a hidden internal target and raises a one-cycle fire pulse when the counter reaches it. It is used by writing a configuration word and a comparator value, then raising the global enable. The configuration selects one-shot or periodic operation and a full-width or 32-bit narrow comparator.

In periodic mode, comparator writes go to a hidden period register. The visible comparator is loaded only when a set-value bit in the configuration is 1. After each fire the channel advances its target by the period and shows the new target on the comparator readback. In narrow mode the target takes its upper half from the counter. A narrow one-shot whose target lies beyond the next 32-bit rollover fires an extra time at that rollover. All control pins are plain, level or single-cycle strobes with no back-pressure. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator readback is all ones, the configuration readback is 0x30 and fire is low. Configuration bit 4 reads 1 for periodic capability and bit 5 reads 1 for full-width capability. The hidden period is zero.
- R2: The target counts as reached when (counter − target), taken as a signed value of the counter width, is not negative. Fire then rises in the cycle after the counter first presents a reached value. This holds across the counter's wrap from all ones to zero.
- R3: Periodic mode is configuration bit 0. With a nonzero period the channel fires once every period counts. After each fire the comparator readback shows the next target.
- R4: If a periodic channel finds its target already passed by several periods, it fires once. The hidden target then advances by one period per clock cycle until it is ahead of the counter, and the channel produces no fire while it catches up.
- R5: A periodic channel whose period is zero fires once and does not reload. Its comparator readback is left unchanged.
- R6: Narrow mode is configuration bit 2. In this mode the target is the counter's upper half joined to the comparator's low half. If that value is below the counter, 2^32 is added to it. Periodic reloads show only the low half on readback.
- R7: In narrow one-shot mode, the channel may find that the extended target is strictly beyond the counter's next 32-bit rollover. It then fires at that rollover and fires again at the extended target. When the target is not beyond the rollover, the channel fires once.
- R8: In periodic mode a comparator write always loads the period. It loads the comparator only when set-value (configuration bit 1) is 1. Any accepted comparator write clears set-value.
- R9: The comparator write strobe selects a half with a flag, where 1 means the upper half. In full-width mode a write replaces only the selected half. In narrow mode an upper-half write is ignored, and a lower-half write zero-extends into the comparator. Entering narrow mode truncates the comparator and the period to their low halves.
- R10: While the global enable is low, no fire occurs and any pending target is cancelled. A rise of the enable recomputes the target from the comparator. A configuration or comparator write made while enabled also recomputes it, so a target that is already passed fires two cycles after the write.
- R11: Fire is a single-cycle pulse. A full-width one-shot fires exactly once per arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the main counter domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_count | input | CW | Shared free-running main counter value |
| glb_en | input | 1 | Global enable; low cancels, rise arms |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | bit0 periodic, bit1 set-value, bit2 narrow |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_hi | input | 1 | Comparator half select, 1 = upper half |
| cmp_wdata | input | CW/2 | Comparator half write data |
| fire | output | 1 | One-cycle fire pulse |
| cmp_rd | output | CW | Visible comparator readback |
| cfg_rd | output | 8 | Configuration readback with capability bits |

## Verification
Two situations are hardest to reach from the ports: the narrow rollover fire and the periodic catch-up. Both need the counter far from where a counting run would bring it in a short test. The bench drives the counter itself and loads it directly, either a few hundred counts below a 32-bit boundary or several periods past a pending periodic target. The bench then computes from the requirements which counter values must produce a fire. The bench also steps the counter near its all-ones wrap and arms a target already behind the counter. These cases exercise the signed reach decision on both sides.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CFG_W        = 8;
  localparam int CFG_WR_W     = 3;
  localparam int CFG_PERIODIC = 0;
  localparam int CFG_SETVAL   = 1;
  localparam int CFG_NARROW   = 2;
  localparam int CAP_PERIODIC = 4;
  localparam int CAP_WIDE     = 5;

  typedef struct packed {
    logic narrow;
    logic setval;
    logic periodic;
  } chan_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CATCH = 2'd2
  } chan_state_t;
endpackage

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_pkg::*;
#(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_WR_W-1:0] cfg_wdata,
  input  logic                cmp_we,
  input  logic                cmp_hi,
  input  logic [HW-1:0]       cmp_wdata,
  input  logic                reload_we,
  input  logic [CW-1:0]       reload_val,
  output chan_mode_t          mode,
  output logic [CW-1:0]       cmp_q,
  output logic [CW-1:0]       period_q,
  output logic                write_evt,
  output logic [CFG_W-1:0]    cfg_rd
);
  localparam logic [CW-HW-1:0] UPPER_ZERO = '0;

  function automatic logic [CW-1:0] merge_half(input logic [CW-1:0] old,
                                               input logic hi,
                                               input logic narrow,
                                               input logic [HW-1:0] d);
    if (narrow)  return {UPPER_ZERO, d};
    else if (hi) return {d, old[HW-1:0]};
    else         return {old[CW-1:HW], d};
  endfunction

  logic cmp_accept;
  logic [CW-1:0] cmp_merge, period_merge;

  assign cmp_accept   = cmp_we && !(mode.narrow && cmp_hi);
  assign cmp_merge    = merge_half(cmp_q, cmp_hi, mode.narrow, cmp_wdata);
  assign period_merge = merge_half(period_q, cmp_hi, mode.narrow, cmp_wdata);
  assign write_evt    = cfg_we || cmp_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      cmp_q    <= '1;
      period_q <= '0;
    end else if (cfg_we) begin
      mode.periodic <= cfg_wdata[CFG_PERIODIC];
      mode.setval   <= cfg_wdata[CFG_SETVAL];
      mode.narrow   <= cfg_wdata[CFG_NARROW];
      if (cfg_wdata[CFG_NARROW]) begin
        cmp_q    <= {UPPER_ZERO, cmp_q[HW-1:0]};
        period_q <= {UPPER_ZERO, period_q[HW-1:0]};
      end
    end else if (cmp_accept) begin
      if (!mode.periodic || mode.setval) cmp_q <= cmp_merge;
      if (mode.periodic) period_q <= period_merge;
      mode.setval <= 1'b0;
    end else if (reload_we) begin
      cmp_q <= mode.narrow ? {UPPER_ZERO, reload_val[HW-1:0]} : reload_val;
    end
  end

  always_comb begin
    cfg_rd               = '0;
    cfg_rd[CFG_PERIODIC] = mode.periodic;
    cfg_rd[CFG_SETVAL]   = mode.setval;
    cfg_rd[CFG_NARROW]   = mode.narrow;
    cfg_rd[CAP_PERIODIC] = 1'b1;
    cfg_rd[CAP_WIDE]     = 1'b1;
  end
endmodule

// File: rtl/evt_target_calc.sv
module evt_target_calc #(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp,
  input  logic          narrow,
  input  logic          periodic,
  output logic [CW-1:0] first_tgt,
  output logic [CW-1:0] real_tgt,
  output logic          wrap_first
);
  localparam logic [CW-1:0] WRAP_STEP = {{(CW-HW-1){1'b0}}, 1'b1, {HW{1'b0}}};
  localparam logic [CW-1:0] LOW_ONES  = {{(CW-HW){1'b0}}, {HW{1'b1}}};

  logic [CW-1:0] joined, extended, next_wrap;

  always_comb begin
    joined     = {count[CW-1:HW], cmp[HW-1:0]};
    extended   = (joined < count) ? joined + WRAP_STEP : joined;
    next_wrap  = (count | LOW_ONES) + 1'b1;
    real_tgt   = narrow ? extended : cmp;
    wrap_first = narrow && !periodic && (extended > next_wrap);
    first_tgt  = wrap_first ? next_wrap : real_tgt;
  end
endmodule

// File: rtl/evt_match.sv
module evt_match #(
  parameter int CW = 64
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] tgt,
  input  logic [CW-1:0] period,
  output logic          hit,
  output logic [CW-1:0] sum,
  output logic          sum_reached
);
  logic [CW-1:0] gap_now, gap_next;

  always_comb begin
    gap_now     = count - tgt;
    sum         = tgt + period;
    gap_next    = count - sum;
    hit         = !gap_now[CW-1];
    sum_reached = !gap_next[CW-1];
  end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_pkg::*;
#(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       main_count,
  input  logic                glb_en,
  input  logic                cfg_we,
  input  logic [CFG_WR_W-1:0] cfg_wdata,
  input  logic                cmp_we,
  input  logic                cmp_hi,
  input  logic [HW-1:0]       cmp_wdata,
  output logic                fire,
  output logic [CW-1:0]       cmp_rd,
  output logic [CFG_W-1:0]    cfg_rd
);
  chan_mode_t    mode;
  logic [CW-1:0] cmp_q, period_q;
  logic          write_evt;
  logic          reload_we;
  logic [CW-1:0] sum;
  logic          hit, sum_reached;
  logic [CW-1:0] first_tgt, real_tgt;
  logic          wrap_first;

  chan_state_t   st_q;
  logic [CW-1:0] tgt_q, real_q;
  logic          wrap_q, en_q, recalc_q, fire_q;
  logic          periodic_run, active;

  evt_chan_regs #(.CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cmp_we     (cmp_we),
    .cmp_hi     (cmp_hi),
    .cmp_wdata  (cmp_wdata),
    .reload_we  (reload_we),
    .reload_val (sum),
    .mode       (mode),
    .cmp_q      (cmp_q),
    .period_q   (period_q),
    .write_evt  (write_evt),
    .cfg_rd     (cfg_rd)
  );

  evt_target_calc #(.CW(CW)) u_calc (
    .count      (main_count),
    .cmp        (cmp_q),
    .narrow     (mode.narrow),
    .periodic   (mode.periodic),
    .first_tgt  (first_tgt),
    .real_tgt   (real_tgt),
    .wrap_first (wrap_first)
  );

  evt_match #(.CW(CW)) u_match (
    .count       (main_count),
    .tgt         (tgt_q),
    .period      (period_q),
    .hit         (hit),
    .sum         (sum),
    .sum_reached (sum_reached)
  );

  assign periodic_run = mode.periodic && (period_q != '0);
  assign active       = glb_en && !recalc_q;
  assign reload_we    = active &&
                        (((st_q == ST_ARMED) && hit && !wrap_q && periodic_run) ||
                         (st_q == ST_CATCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tgt_q    <= '0;
      real_q   <= '0;
      wrap_q   <= 1'b0;
      en_q     <= 1'b0;
      recalc_q <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      en_q     <= glb_en;
      recalc_q <= glb_en && (!en_q || write_evt);
      fire_q   <= 1'b0;
      if (!glb_en) begin
        st_q   <= ST_IDLE;
        wrap_q <= 1'b0;
      end else if (recalc_q) begin
        tgt_q  <= first_tgt;
        real_q <= real_tgt;
        wrap_q <= wrap_first;
        st_q   <= ST_ARMED;
      end else begin
        case (st_q)
          ST_ARMED: begin
            if (hit) begin
              fire_q <= 1'b1;
              if (wrap_q) begin
                tgt_q  <= real_q;
                wrap_q <= 1'b0;
              end else if (periodic_run) begin
                tgt_q <= sum;
                st_q  <= sum_reached ? ST_CATCH : ST_ARMED;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_CATCH: begin
            tgt_q <= sum;
            if (!sum_reached) st_q <= ST_ARMED;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign fire   = fire_q;
  assign cmp_rd = cmp_q;
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          cfg_we,
  input logic          cmp_we,
  input logic          cmp_hi,
  input logic          fire,
  input logic [CW-1:0] cmp_rd,
  input logic [2:0]    mode_rd
);
  assert_no_fire_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !fire);

  assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd[2] |-> (cmp_rd[CW-1:HW] == '0));

  assert_hi_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && cmp_hi && mode_rd[2] && !cfg_we && !glb_en) |=> $stable(cmp_rd));

  assert_setval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !(cmp_hi && mode_rd[2]) && !cfg_we) |=> !mode_rd[1]);

  assert_oneshot_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_rd[0] && !mode_rd[2]) |=> !fire);
endmodule

bind evt_cmp_channel evt_chan_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .glb_en  (glb_en),
  .cfg_we  (cfg_we),
  .cmp_we  (cmp_we),
  .cmp_hi  (cmp_hi),
  .fire    (fire),
  .cmp_rd  (cmp_rd),
  .mode_rd (cfg_rd[2:0])
);

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        ld = 1'b0;
  logic [63:0] ld_val = '0;
  logic        glb_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic        cmp_we = 1'b0;
  logic        cmp_hi = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic        fire;
  logic [63:0] cmp_rd;
  logic [7:0]  cfg_rd;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  string       cur_req = "R1";

  evt_cmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .main_count(cnt), .glb_en(glb_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cmp_we(cmp_we), .cmp_hi(cmp_hi),
    .cmp_wdata(cmp_wdata), .fire(fire), .cmp_rd(cmp_rd), .cfg_rd(cfg_rd)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (ld) cnt <= ld_val;
    else    cnt <= cnt + 64'd1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each fire must match the oldest expected counter value
  initial forever begin
    @(negedge clk);
    if (rst_n && fire) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " unexpected fire"}, cnt - 64'd1, '0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check((cnt - 64'd1) == e, t, cnt - 64'd1, e);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    summary();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_cfg(input bit p, input bit s, input bit nw);
    cfg_we = 1'b1; cfg_wdata = {nw, s, p};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask
  task automatic wr_cmp(input bit hi, input logic [31:0] d);
    cmp_we = 1'b1; cmp_hi = hi; cmp_wdata = d;
    @(negedge clk);
    cmp_we = 1'b0; cmp_hi = 1'b0;
  endtask
  task automatic set_en(input bit v);
    glb_en = v;
    @(negedge clk);
  endtask
  task automatic load_cnt(input logic [63:0] v);
    ld = 1'b1; ld_val = v;
    @(negedge clk);
    ld = 1'b0;
  endtask
  task automatic expect_fire(input logic [63:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask
  task automatic wait_cnt(input logic [63:0] v);
    while (cnt != v) @(negedge clk);
  endtask
  task automatic drain(input string t);
    check(exp_q.size() == 0, {t, " missing fire"}, 64'(exp_q.size()), '0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    logic [63:0] t0, x, nt, c;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(cmp_rd == '1, "R1 cmp reset", cmp_rd, '1);
    check(cfg_rd == 8'h30, "R1 cfg reset", 64'(cfg_rd), 64'h30);
    check(fire == 1'b0, "R1 fire reset", 64'(fire), 0);

    // R2 / R11 full-width one-shot armed by enable rise (R10)
    cur_req = "R2";
    wr_cfg(0, 0, 0);
    wr_cmp(1, 32'h0);
    t0 = cnt + 64'd40;
    wr_cmp(0, t0[31:0]);
    expect_fire(t0, "R2 one-shot");
    set_en(1);
    wait_cnt(t0 + 64'd1);
    check(fire == 1'b1, "R11 pulse high", 64'(fire), 1);
    tick(1);
    check(fire == 1'b0, "R11 pulse low", 64'(fire), 0);
    wait_cnt(t0 + 64'd20);
    drain("R11");
    check(cmp_rd == t0, "R2 cmp kept", cmp_rd, t0);

    // R10 write while enabled with a passed target
    cur_req = "R10";
    load_cnt(64'd1000);
    x = cnt;
    wr_cmp(0, 32'd900);
    expect_fire(x + 64'd2, "R10 write recompute");
    tick(10);
    drain("R10");

    // R2 across counter wrap
    cur_req = "R2";
    set_en(0);
    load_cnt(64'hFFFF_FFFF_FFFF_FFEC);
    wr_cmp(0, 32'd5);
    expect_fire(64'd5, "R2 wrap");
    set_en(1);
    tick(40);
    drain("R2");

    // R3 / R8 periodic, then R10 cancel on enable fall
    cur_req = "R3";
    set_en(0);
    wr_cfg(1, 1, 0);
    check(cfg_rd == 8'h33, "R8 setval set", 64'(cfg_rd), 64'h33);
    t0 = cnt + 64'd60;
    wr_cmp(0, t0[31:0]);
    check(cfg_rd[1] == 1'b0, "R8 setval clear", 64'(cfg_rd), 64'h31);
    check(cmp_rd == t0, "R8 cmp loaded", cmp_rd, t0);
    wr_cmp(0, 32'd25);
    check(cmp_rd == t0, "R8 period only", cmp_rd, t0);
    expect_fire(t0, "R3 first");
    expect_fire(t0 + 64'd25, "R3 second");
    expect_fire(t0 + 64'd50, "R3 third");
    set_en(1);
    wait_cnt(t0 + 64'd3);
    check(cmp_rd == t0 + 64'd25, "R3 cmp reload", cmp_rd, t0 + 64'd25);
    wait_cnt(t0 + 64'd55);
    cur_req = "R10";
    set_en(0);
    tick(80);
    drain("R10");

    // R4 catch-up after a counter jump
    cur_req = "R4";
    wr_cfg(1, 1, 0);
    t0 = cnt + 64'd60;
    wr_cmp(0, t0[31:0]);
    wr_cmp(0, 32'd25);
    expect_fire(t0, "R4 first");
    set_en(1);
    wait_cnt(t0 + 64'd5);
    expect_fire(t0 + 64'd257, "R4 jump fire");
    load_cnt(t0 + 64'd257);
    nt = t0 + 64'd50;
    c  = t0 + 64'd257;
    while (c >= nt) begin
      c  = c + 64'd1;
      nt = nt + 64'd25;
    end
    expect_fire(nt, "R4 after catch-up");
    wait_cnt(nt - 64'd2);
    check(cmp_rd == nt, "R4 cmp caught up", cmp_rd, nt);
    wait_cnt(nt + 64'd3);
    check(cmp_rd == nt + 64'd25, "R4 cmp next", cmp_rd, nt + 64'd25);
    set_en(0);
    tick(5);
    drain("R4");

    // R5 zero period
    cur_req = "R5";
    wr_cfg(1, 1, 0);
    t0 = cnt + 64'd60;
    wr_cmp(0, t0[31:0]);
    wr_cmp(0, 32'd0);
    expect_fire(t0, "R5 single");
    set_en(1);
    wait_cnt(t0 + 64'd100);
    drain("R5");
    check(cmp_rd == t0, "R5 cmp kept", cmp_rd, t0);
    set_en(0);

    // R9 narrow write rules
    cur_req = "R9";
    wr_cfg(0, 0, 0);
    wr_cmp(1, 32'hABCD);
    wr_cmp(0, 32'h1234);
    check(cmp_rd == 64'h0000ABCD_00001234, "R9 wide halves", cmp_rd, 64'h0000ABCD_00001234);
    wr_cfg(0, 0, 1);
    check(cmp_rd == 64'h1234, "R9 truncate", cmp_rd, 64'h1234);
    check(cfg_rd == 8'h34, "R9 cfg narrow", 64'(cfg_rd), 64'h34);
    wr_cmp(1, 32'h77);
    check(cmp_rd == 64'h1234, "R9 hi ignored", cmp_rd, 64'h1234);
    wr_cmp(0, 32'h9999);
    check(cmp_rd == 64'h9999, "R9 lo zero-ext", cmp_rd, 64'h9999);

    // R6 narrow periodic extension
    cur_req = "R6";
    wr_cfg(1, 1, 1);
    load_cnt(64'h5_FFFF_FF00);
    wr_cmp(0, 32'h40);
    wr_cmp(0, 32'h100);
    expect_fire(64'h6_0000_0040, "R6 extended");
    expect_fire(64'h6_0000_0140, "R6 reload");
    set_en(1);
    wait_cnt(64'h6_0000_0050);
    check(cmp_rd == 64'h140, "R6 cmp low half", cmp_rd, 64'h140);
    wait_cnt(64'h6_0000_0150);
    check(cmp_rd == 64'h240, "R6 cmp second", cmp_rd, 64'h240);
    set_en(0);
    drain("R6");

    // R7 narrow one-shot: no rollover fire, then rollover fire
    cur_req = "R7";
    wr_cfg(0, 0, 1);
    load_cnt(64'h5_FFFF_FF00);
    wr_cmp(0, 32'hFFFF_FF80);
    expect_fire(64'h5_FFFF_FF80, "R7 in range");
    set_en(1);
    wait_cnt(64'h6_0000_0020);
    drain("R7");
    set_en(0);
    load_cnt(64'h5_FFFF_FF00);
    wr_cmp(0, 32'h40);
    expect_fire(64'h6_0000_0000, "R7 rollover");
    expect_fire(64'h6_0000_0040, "R7 real target");
    set_en(1);
    wait_cnt(64'h6_0000_0080);
    drain("R7");
    check(cmp_rd == 64'h40, "R7 cmp kept", cmp_rd, 64'h40);
    set_en(0);

    tick(5);
    summary();
    $finish;
  end
endmodule